// File: doc/BRIEF.md
# Media Change Latch with Head Step Tracking

This block keeps the "media may have changed" indicator of a floppy drive interface. A drive model supplies a media-present level. The controller's seek logic supplies seek requests, each carrying a target cylinder. The block has a small step sequencer. It moves the head one cylinder at a time toward the target, one step every `STEP_GAP` clock cycles, and keeps the present cylinder number.

The change indicator is set at reset and set whenever no media is present. It is cleared only by a real head step that happens while media is present. Reading the indicator never clears it. A seek to the cylinder the head already occupies produces no step, so it does not clear it either. Software sees the indicator as the top bit of an 8-bit input register, captured on a read strobe.

Top module: `media_change_latch`

## Requirements
- R1: After synchronous reset, the indicator is set, `cur_cyl` is 0, and `seek_busy` and `step_pulse` are 0.
- R2: A read strobe loads `rd_data` on the next clock edge. Bit 7 holds the indicator and bits 6..0 read 0. Reading any number of times leaves the indicator unchanged.
- R3: While `media_present` is 0, the indicator is set, including across seeks that produce steps.
- R4: Inserting media (`media_present` rising) leaves the indicator set until a step occurs.
- R5: A seek whose target equals `cur_cyl` produces no step, does not raise `seek_busy`, and leaves the indicator unchanged.
- R6: A seek to a different cylinder raises `seek_busy`. It then produces exactly |target - `cur_cyl`| one-cycle step pulses, spaced `STEP_GAP` cycles apart. `step_dir` is 1 when stepping toward higher cylinders and 0 toward lower ones. `cur_cyl` moves by one per step and ends at the target, and `seek_busy` drops with the last step.
- R7: A step pulse while media is present clears the indicator on the following clock edge.
- R8: Removing media (`media_present` falling) sets the indicator on the next clock edge.
- R9: A seek request made while `seek_busy` is 1 is ignored; the running seek still ends at its own target.
- R10: `cur_cyl` follows seeks whether or not media is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| media_present | input | 1 | 1 while a medium is in the drive |
| seek_valid | input | 1 | One-cycle seek request |
| seek_cyl | input | CYL_W | Target cylinder of the seek |
| rd_en | input | 1 | Read strobe for the input register |
| rd_data | output | 8 | Input register value; bit 7 is the change indicator |
| cur_cyl | output | CYL_W | Cylinder the head currently occupies |
| seek_busy | output | 1 | Seek in progress |
| step_pulse | output | 1 | One-cycle step pulse |
| step_dir | output | 1 | Step direction, 1 toward higher cylinders |

## Verification
The indicator is driven through the three ways it can stay set and the single way it can clear. Repeated reads with no media separate a read-clears latch from a sticky one. A seek with no media that still steps shows that only media-present steps clear the flag. Seeks to the present cylinder after insertion, upward and downward multi-track seeks, and an overlapping seek request show in turn: that a same-track seek has no effect, step count, spacing and direction, cylinder tracking, and the rule that a seek cannot be taken while another is running. An eject after the flag has cleared, followed by stepping seeks, confirms that removal sets the flag again and that it stays set.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_MOVE = 1'b1
  } seq_state_e;

  localparam int unsigned REG_W    = 8;
  localparam int unsigned FLAG_POS = 7;

endpackage

// File: rtl/mcl_step_seq.sv
module mcl_step_seq
  import mcl_pkg::*;
#(
  parameter int unsigned CYL_W    = 8,
  parameter int unsigned STEP_GAP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seek_valid,
  input  logic [CYL_W-1:0] seek_cyl,
  output logic             busy,
  output logic             step_pulse,
  output logic             step_dir,
  output logic [CYL_W-1:0] cur_cyl
);

  localparam int unsigned GAP_W = (STEP_GAP > 1) ? $clog2(STEP_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(STEP_GAP - 1);

  seq_state_e       state_q;
  logic [CYL_W-1:0] tgt_q;
  logic [GAP_W-1:0] gap_q;
  logic [CYL_W-1:0] next_cyl;

  assign next_cyl = step_dir ? (cur_cyl + 1'b1) : (cur_cyl - 1'b1);
  assign busy     = (state_q == SEQ_MOVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      tgt_q      <= '0;
      gap_q      <= '0;
      cur_cyl    <= '0;
      step_pulse <= 1'b0;
      step_dir   <= 1'b0;
    end else begin
      step_pulse <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (seek_valid) begin
            tgt_q <= seek_cyl;
            if (seek_cyl != cur_cyl) begin
              state_q  <= SEQ_MOVE;
              step_dir <= (seek_cyl > cur_cyl);
              gap_q    <= GAP_LOAD;
            end
          end
        end
        SEQ_MOVE: begin
          if (gap_q == '0) begin
            step_pulse <= 1'b1;
            cur_cyl    <= next_cyl;
            gap_q      <= GAP_LOAD;
            if (next_cyl == tgt_q) state_q <= SEQ_IDLE;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mcl_flag.sv
module mcl_flag (
  input  logic clk,
  input  logic rst,
  input  logic media_present,
  input  logic step_pulse,
  output logic chg_flag
);

  always_ff @(posedge clk) begin
    if (rst)                chg_flag <= 1'b1;
    else if (!media_present) chg_flag <= 1'b1;
    else if (step_pulse)    chg_flag <= 1'b0;
  end

endmodule

// File: rtl/mcl_rd_port.sv
module mcl_rd_port
  import mcl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             chg_flag,
  output logic [REG_W-1:0] rd_data
);

  logic [REG_W-1:0] reg_view;

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i == FLAG_POS) begin : g_flag
      assign reg_view[i] = chg_flag;
    end else begin : g_zero
      assign reg_view[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= reg_view;
  end

endmodule

// File: rtl/media_change_latch.sv
module media_change_latch
  import mcl_pkg::*;
#(
  parameter int unsigned CYL_W    = 8,
  parameter int unsigned STEP_GAP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             media_present,
  input  logic             seek_valid,
  input  logic [CYL_W-1:0] seek_cyl,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  output logic [CYL_W-1:0] cur_cyl,
  output logic             seek_busy,
  output logic             step_pulse,
  output logic             step_dir
);

  logic chg_flag;

  mcl_step_seq #(.CYL_W(CYL_W), .STEP_GAP(STEP_GAP)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .seek_valid (seek_valid),
    .seek_cyl   (seek_cyl),
    .busy       (seek_busy),
    .step_pulse (step_pulse),
    .step_dir   (step_dir),
    .cur_cyl    (cur_cyl)
  );

  mcl_flag u_flag (
    .clk           (clk),
    .rst           (rst),
    .media_present (media_present),
    .step_pulse    (step_pulse),
    .chg_flag      (chg_flag)
  );

  mcl_rd_port u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .chg_flag (chg_flag),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/media_change_latch_chk.sv
module media_change_latch_chk #(
  parameter int unsigned CYL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             media_present,
  input logic             seek_valid,
  input logic [CYL_W-1:0] seek_cyl,
  input logic             rd_en,
  input logic [7:0]       rd_data,
  input logic [CYL_W-1:0] cur_cyl,
  input logic             seek_busy,
  input logic             step_pulse,
  input logic             step_dir,
  input logic             chg_flag
);

  a_r3_absent_sets: assert property (@(posedge clk) disable iff (rst)
    !media_present |=> chg_flag);

  a_r7_step_clears: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && media_present) |=> !chg_flag);

  a_r4_fall_needs_step: assert property (@(posedge clk) disable iff (rst)
    $fell(chg_flag) |-> $past(step_pulse));

  a_r2_read_view: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data == {$past(chg_flag), 7'b0}));

  a_r5_same_no_busy: assert property (@(posedge clk) disable iff (rst)
    (seek_valid && !seek_busy && seek_cyl == cur_cyl) |=> !seek_busy);

  a_r6_step_up: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && step_dir) |-> cur_cyl == $past(cur_cyl) + 1'b1);

  a_r6_step_down: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && !step_dir) |-> cur_cyl == $past(cur_cyl) - 1'b1);

  a_r9_step_in_seek: assert property (@(posedge clk) disable iff (rst)
    step_pulse |-> $past(seek_busy));

endmodule

bind media_change_latch media_change_latch_chk #(.CYL_W(CYL_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .media_present (media_present),
  .seek_valid    (seek_valid),
  .seek_cyl      (seek_cyl),
  .rd_en         (rd_en),
  .rd_data       (rd_data),
  .cur_cyl       (cur_cyl),
  .seek_busy     (seek_busy),
  .step_pulse    (step_pulse),
  .step_dir      (step_dir),
  .chg_flag      (chg_flag)
);

// File: tb/media_change_latch_bench.sv
module media_change_latch_bench;

  localparam int unsigned CYL_W    = 8;
  localparam int unsigned STEP_GAP = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             media_present = 1'b0;
  logic             seek_valid = 1'b0;
  logic [CYL_W-1:0] seek_cyl = '0;
  logic             rd_en = 1'b0;
  logic [7:0]       rd_data;
  logic [CYL_W-1:0] cur_cyl;
  logic             seek_busy, step_pulse, step_dir;

  always #5 clk = ~clk;

  media_change_latch #(.CYL_W(CYL_W), .STEP_GAP(STEP_GAP)) u_media_change_latch (
    .clk(clk), .rst(rst), .media_present(media_present),
    .seek_valid(seek_valid), .seek_cyl(seek_cyl), .rd_en(rd_en),
    .rd_data(rd_data), .cur_cyl(cur_cyl), .seek_busy(seek_busy),
    .step_pulse(step_pulse), .step_dir(step_dir)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // scoreboard queues
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  // step monitor
  int  steps = 0;
  int  cyc = 0;
  int  last_step_cyc = -1;
  int  gap_bad = 0;
  int  dir_up = 0;
  int  dir_dn = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    cyc++;
    if (step_pulse) begin
      if (last_step_cyc >= 0 && seek_busy_prev && (cyc - last_step_cyc) != STEP_GAP) gap_bad++;
      last_step_cyc = cyc;
      steps++;
      if (step_dir) dir_up++; else dir_dn++;
    end
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 scoreboard underflow", 0, 1);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  logic seek_busy_prev = 1'b0;
  always @(negedge clk) seek_busy_prev <= seek_busy;

  task automatic do_read(input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic reset_counts();
    steps = 0; dir_up = 0; dir_dn = 0; gap_bad = 0; last_step_cyc = -1;
  endtask

  task automatic seek(input int c);
    @(negedge clk);
    seek_valid = 1'b1;
    seek_cyl   = CYL_W'(c);
    @(negedge clk);
    seek_valid = 1'b0;
    while (seek_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cur_cyl == 0, "R1 cur_cyl", cur_cyl, 0);
    check(!seek_busy && !step_pulse, "R1 idle", {seek_busy, step_pulse}, 0);
    // R2 R3 repeated reads with no media
    do_read(8'h80, "R2 first read no media");
    do_read(8'h80, "R2 second read no media");
    // R10 R3 seek without media steps but leaves flag set
    reset_counts();
    seek(1);
    check(cur_cyl == 1, "R10 cur_cyl after seek no media", cur_cyl, 1);
    check(steps == 1, "R3 one step no media", steps, 1);
    do_read(8'h80, "R3 flag set after step no media");
    // R4 insert
    media_present = 1'b1;
    repeat (2) @(negedge clk);
    do_read(8'h80, "R4 flag set after insert");
    // R5 same cylinder
    reset_counts();
    @(negedge clk);
    seek_valid = 1'b1; seek_cyl = 8'd1;
    @(negedge clk);
    seek_valid = 1'b0;
    check(!seek_busy, "R5 no busy on same cyl", seek_busy, 0);
    repeat (2 * STEP_GAP) @(negedge clk);
    check(steps == 0, "R5 no step on same cyl", steps, 0);
    do_read(8'h80, "R5 flag kept on same cyl");
    // R7 step clears
    reset_counts();
    seek(0);
    check(steps == 1 && dir_dn == 1, "R6 one step down", dir_dn, 1);
    do_read(8'h00, "R7 flag cleared by step");
    do_read(8'h00, "R2 read keeps cleared flag");
    // R6 multi-track upward
    reset_counts();
    seek(3);
    check(steps == 3, "R6 step count up", steps, 3);
    check(dir_up == 3, "R6 direction up", dir_up, 3);
    check(gap_bad == 0, "R6 step spacing", gap_bad, 0);
    check(cur_cyl == 3, "R6 final cylinder", cur_cyl, 3);
    // R8 eject
    media_present = 1'b0;
    @(negedge clk);
    do_read(8'h80, "R8 flag set by eject");
    reset_counts();
    seek(0);
    check(steps == 3 && dir_dn == 3, "R6 step count down", dir_dn, 3);
    do_read(8'h80, "R3 flag kept after steps no media");
    seek(2);
    check(cur_cyl == 2, "R10 cur_cyl no media", cur_cyl, 2);
    do_read(8'h80, "R3 flag kept after second seek");
    // R9 overlapping seek ignored
    media_present = 1'b1;
    @(negedge clk);
    reset_counts();
    @(negedge clk);
    seek_valid = 1'b1; seek_cyl = 8'd5;
    @(negedge clk);
    seek_cyl = 8'd0;
    repeat (2) @(negedge clk);
    seek_valid = 1'b0;
    while (seek_busy) @(negedge clk);
    repeat (2 * STEP_GAP) @(negedge clk);
    check(cur_cyl == 5, "R9 busy seek ignored", cur_cyl, 5);
    check(steps == 3, "R9 step count", steps, 3);
    do_read(8'h00, "R7 flag cleared after insert and step");
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule